// File: doc/BRIEF.md
# HDLC Receive Frame Checker

This block sits after an HDLC deframer that has already removed flags and zero-bit stuffing. Its input is a byte stream. The first byte of each frame carries a start marker, a separate strobe stands for the closing flag, and another strobe reports a remote abort. The block checks the trailing frame check sequence (FCS) with either a 16-bit CCITT CRC or a 32-bit CRC. It watches the frame length against a programmable ceiling and passes payload bytes on to a receive buffer. Each frame is closed with one status byte, and a one-cycle message-end interrupt is raised at the same time.

Three mode inputs shape the byte stream:

- A forward mode passes the FCS bytes to the buffer as ordinary data, and the CRC is still verified.
- A no-check mode switches CRC handling off completely. No trailing bytes are treated as FCS.
- A length guard, when enabled, cuts a frame off as soon as it grows past (L+1)*32 bytes. The frame is then reported as aborted.

Top module: `hdlc_rx_fcheck`

## Requirements
- R1: With `cfg_crc32`=0 the CRC is CRC-16/CCITT. It is reflected (polynomial 0x8408, LSB first), preset to 0xFFFF and run over every frame byte including the 2-byte FCS. The FCS is sent low byte first. The CRC is good when the register ends at 0xF0B8, and status bit 5 is then 1.
- R2: With `cfg_crc32`=1 the CRC is the reflected 32-bit CRC (polynomial 0xEDB88320), preset to 0xFFFFFFFF and run over every byte including the 4-byte FCS, sent LSB first. It is good when the register ends at 0xDEBB20E3.
- R3: When checking is on and forwarding is off, the last 2 (CRC-16) or 4 (CRC-32) bytes of a frame never reach `out_data`. All earlier bytes come out in order.
- R4: With `cfg_fwd_crc`=1 every frame byte, FCS included, comes out as data before the status byte, and status bit 5 still reports the CRC result.
- R5: With `cfg_no_check`=1 every frame byte comes out as data and status bit 5 is always 0.
- R6: Status bit 7 (valid frame) is 1 on a closing flag when the frame held at least FCS length + 1 bytes. The FCS length is 0 in no-check mode.
- R7: Each frame ends with exactly one status byte, after all of its data bytes, with `out_is_status`=1. Bit 7 is valid, bit 5 is CRC good, bit 4 is abort, and bits 6 and 3..0 are 0.
- R8: An abort strobe inside a frame yields status 0x10 after the data bytes already released. The held bytes are dropped.
- R9: With `cfg_len_en`=1 and limit (`cfg_len_blocks`+1)*32 bytes, the arrival of byte limit+1 yields status 0x10 at once. That byte, the rest of the frame and its closing strobe are discarded. A frame of exactly the limit length is accepted normally.
- R10: With `cfg_len_en`=0 frames longer than the programmed limit complete normally.
- R11: `msg_end_irq` is a one-cycle pulse, high exactly in the cycles where a status byte is output.
- R12: After reset no output is valid. Bytes without a start marker and closing or abort strobes that arrive outside a frame produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_crc32 | input | 1 | 0: CRC-16/CCITT, 1: CRC-32 |
| cfg_fwd_crc | input | 1 | Pass FCS bytes on as data |
| cfg_no_check | input | 1 | Disable CRC handling |
| cfg_len_en | input | 1 | Enable the length ceiling |
| cfg_len_blocks | input | RL_W (11) | Ceiling in 32-byte blocks minus one |
| in_valid | input | 1 | Byte present on `in_data` |
| in_sof | input | 1 | Byte is the first of a frame |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Closing flag seen (no byte) |
| in_abort | input | 1 | Remote abort seen |
| out_valid | output | 1 | Output byte valid |
| out_is_status | output | 1 | Output byte is the status byte |
| out_data | output | 8 | Data or status byte |
| msg_end_irq | output | 1 | Message-end interrupt pulse |

## Verification
The hardest condition to reach from the ports is the length ceiling. It needs a frame of at least 33 bytes with the guard enabled, and it must be driven on both sides of the boundary. The bench sends frames of exactly the limit and of the limit plus one at two block settings and with both CRC widths. It then sends a closing strobe after the cut-off frame, so that the drop state is shown to swallow it. Short frames made only of an FCS are swept with good and corrupted CRCs to separate the valid bit from the CRC bit.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RECV = 2'd1,
      ST_DROP = 2'd2
   } rx_state_e;

   localparam logic [15:0] C16_PRESET  = 16'hFFFF;
   localparam logic [15:0] C16_RESIDUE = 16'hF0B8;
   localparam logic [15:0] C16_POLY    = 16'h8408;
   localparam logic [31:0] C32_PRESET  = 32'hFFFF_FFFF;
   localparam logic [31:0] C32_RESIDUE = 32'hDEBB_20E3;
   localparam logic [31:0] C32_POLY    = 32'hEDB8_8320;

   localparam int BIT_VALID = 7;
   localparam int BIT_CRCOK = 5;
   localparam int BIT_ABORT = 4;

   function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ C16_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction

   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ C32_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction

   function automatic logic [7:0] pack_status(input logic vld, input logic crc_ok, input logic abrt);
      logic [7:0] s;
      s = 8'h00;
      s[BIT_VALID] = vld;
      s[BIT_CRCOK] = crc_ok;
      s[BIT_ABORT] = abrt;
      return s;
   endfunction

endpackage

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit
   import hdlc_rx_pkg::*;
#(
   parameter int SUPPORT_CRC32 = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       restart,
   input  logic [7:0] din,
   input  logic       use32,
   output logic       crc_ok
);

   logic [15:0] c16_q;
   logic        ok16;
   logic        ok32;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    c16_q <= C16_PRESET;
      else if (step) c16_q <= crc16_step(restart ? C16_PRESET : c16_q, din);
   end

   assign ok16 = (c16_q == C16_RESIDUE);

   generate
      if (SUPPORT_CRC32 != 0) begin : g_c32
         logic [31:0] c32_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    c32_q <= C32_PRESET;
            else if (step) c32_q <= crc32_step(restart ? C32_PRESET : c32_q, din);
         end
         assign ok32 = (c32_q == C32_RESIDUE);
      end else begin : g_no32
         assign ok32 = 1'b0;
      end
   endgenerate

   assign crc_ok = use32 ? ok32 : ok16;

endmodule

// File: rtl/hdlc_hold_line.sv
module hdlc_hold_line #(
   parameter int MAX_HOLD = 4,
   parameter int DEPTH_W  = $clog2(MAX_HOLD + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic               restart,
   input  logic [7:0]         din,
   input  logic [DEPTH_W-1:0] depth,
   output logic               emit,
   output logic [7:0]         emit_data
);

   logic [7:0]         sr [MAX_HOLD];
   logic [DEPTH_W-1:0] fill_q;
   logic [DEPTH_W-1:0] fill_eff;

   if (MAX_HOLD < 1) begin : g_bad_depth
      $error("hdlc_hold_line: MAX_HOLD must be at least 1");
   end

   assign fill_eff = restart ? '0 : fill_q;
   assign emit     = push && (fill_eff >= depth);

   always_comb begin
      emit_data = din;
      for (int i = 0; i < MAX_HOLD; i++) begin
         if (depth == DEPTH_W'(i + 1)) emit_data = sr[i];
      end
   end

   always_ff @(posedge clk) begin
      if (push) sr[0] <= din;
   end

   for (genvar g = 1; g < MAX_HOLD; g++) begin : g_shift
      always_ff @(posedge clk) begin
         if (push) sr[g] <= sr[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fill_q <= '0;
      else if (push) begin
         if (fill_eff != DEPTH_W'(MAX_HOLD)) fill_q <= fill_eff + DEPTH_W'(1);
         else                               fill_q <= fill_eff;
      end
   end

   AST_HOLD_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (depth <= DEPTH_W'(MAX_HOLD))); // R3

endmodule

// File: rtl/hdlc_len_guard.sv
module hdlc_len_guard #(
   parameter int RL_W   = 11,
   parameter int BLK_SH = 5,
   parameter int CNT_W  = RL_W + BLK_SH + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic             en,
   input  logic [RL_W-1:0]  blocks,
   output logic [CNT_W-1:0] count,
   output logic             over
);

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] limit;

   if (CNT_W < RL_W + BLK_SH + 1) begin : g_bad_width
      $error("hdlc_len_guard: counter too narrow for the largest limit");
   end

   assign limit = (CNT_W'(blocks) + CNT_W'(1)) << BLK_SH;
   assign over  = step && !restart && en && (count_q == limit);
   assign count = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else if (step && !over) count_q <= restart ? CNT_W'(1) : count_q + CNT_W'(1);
   end

   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      over |=> (count_q == $past(count_q))); // R9

endmodule

// File: rtl/hdlc_rx_fcheck.sv
module hdlc_rx_fcheck
   import hdlc_rx_pkg::*;
#(
   parameter int RL_W          = 11,
   parameter int BLK_SH        = 5,
   parameter int SUPPORT_CRC32 = 1,
   parameter int MAX_HOLD      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_crc32,
   input  logic            cfg_fwd_crc,
   input  logic            cfg_no_check,
   input  logic            cfg_len_en,
   input  logic [RL_W-1:0] cfg_len_blocks,
   input  logic            in_valid,
   input  logic            in_sof,
   input  logic [7:0]      in_data,
   input  logic            in_eof,
   input  logic            in_abort,
   output logic            out_valid,
   output logic            out_is_status,
   output logic [7:0]      out_data,
   output logic            msg_end_irq
);

   localparam int CNT_W   = RL_W + BLK_SH + 1;
   localparam int DEPTH_W = $clog2(MAX_HOLD + 1);

   if (MAX_HOLD < ((SUPPORT_CRC32 != 0) ? 4 : 2)) begin : g_bad_hold
      $error("hdlc_rx_fcheck: MAX_HOLD too small for the widest FCS");
   end

   rx_state_e          st_q;
   logic               use32;
   logic [DEPTH_W-1:0] fcs_len;
   logic [DEPTH_W-1:0] hold_depth;
   logic [CNT_W-1:0]   min_len;
   logic               take_byte;
   logic               restart;
   logic               push;
   logic               over;
   logic [CNT_W-1:0]   count;
   logic               crc_ok;
   logic               emit;
   logic [7:0]         emit_data;
   logic               end_close;
   logic               end_abort;

   // ---------------- configuration decode ----------------
   assign use32      = (SUPPORT_CRC32 != 0) && cfg_crc32;
   assign fcs_len    = cfg_no_check ? '0 : (use32 ? DEPTH_W'(4) : DEPTH_W'(2));
   assign hold_depth = (cfg_no_check || cfg_fwd_crc) ? '0 : fcs_len;
   assign min_len    = CNT_W'(fcs_len) + CNT_W'(1);

   // ---------------- event decode ----------------
   assign take_byte = in_valid && !in_eof && !in_abort && (in_sof || st_q == ST_RECV);
   assign restart   = take_byte && in_sof;
   assign push      = take_byte && !over;
   assign end_close = in_eof && !in_abort && (st_q == ST_RECV);
   assign end_abort = in_abort && (st_q == ST_RECV);

   hdlc_len_guard #(
      .RL_W   (RL_W),
      .BLK_SH (BLK_SH),
      .CNT_W  (CNT_W)
   ) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (take_byte),
      .restart (restart),
      .en      (cfg_len_en),
      .blocks  (cfg_len_blocks),
      .count   (count),
      .over    (over)
   );

   hdlc_crc_unit #(
      .SUPPORT_CRC32 (SUPPORT_CRC32)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (push),
      .restart (restart),
      .din     (in_data),
      .use32   (use32),
      .crc_ok  (crc_ok)
   );

   hdlc_hold_line #(
      .MAX_HOLD (MAX_HOLD),
      .DEPTH_W  (DEPTH_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .restart   (restart),
      .din       (in_data),
      .depth     (hold_depth),
      .emit      (emit),
      .emit_data (emit_data)
   );

   // ---------------- frame state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else if (in_abort || in_eof)  st_q <= ST_IDLE;
      else if (take_byte && over)   st_q <= ST_DROP;
      else if (restart)             st_q <= ST_RECV;
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_is_status <= 1'b0;
         out_data      <= 8'h00;
         msg_end_irq   <= 1'b0;
      end else begin
         out_valid     <= 1'b0;
         out_is_status <= 1'b0;
         msg_end_irq   <= 1'b0;
         if (end_abort || (take_byte && over)) begin
            out_valid     <= 1'b1;
            out_is_status <= 1'b1;
            out_data      <= pack_status(1'b0, 1'b0, 1'b1);
            msg_end_irq   <= 1'b1;
         end else if (end_close) begin
            out_valid     <= 1'b1;
            out_is_status <= 1'b1;
            out_data      <= pack_status(count >= min_len, !cfg_no_check && crc_ok, 1'b0);
            msg_end_irq   <= 1'b1;
         end else if (emit) begin
            out_valid     <= 1'b1;
            out_data      <= emit_data;
         end
      end
   end

   // ---------------- assertions ----------------
   AST_STATUS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_is_status) |-> (out_data[6] == 1'b0 && out_data[3:0] == 4'h0)); // R7

   AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_is_status && out_data[BIT_ABORT]) |-> (out_data[7:5] == 3'b000)); // R8

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_end_irq |=> !msg_end_irq); // R11

   AST_NOCHECK_NO_CRCOK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_no_check && end_close) |=> !out_data[BIT_CRCOK]); // R5

   AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DROP && !restart) |=> !out_valid); // R9

endmodule

// File: tb/hdlc_rx_fcheck_tb.sv
`timescale 1ns/1ps
module hdlc_rx_fcheck_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_crc32 = 0, cfg_fwd_crc = 0, cfg_no_check = 0, cfg_len_en = 0;
   logic [10:0] cfg_len_blocks = '0;
   logic        in_valid = 0, in_sof = 0, in_eof = 0, in_abort = 0;
   logic [7:0]  in_data = '0;
   logic        out_valid, out_is_status, msg_end_irq;
   logic [7:0]  out_data;

   int n_cmp = 0;
   int n_bad = 0;
   int irq_n = 0;
   int irq_skew = 0;
   logic [8:0] got_q[$];
   logic [8:0] exp_q[$];
   logic [7:0] fr [0:199];
   int fr_n = 0;

   always #2.5 clk = ~clk;

   hdlc_rx_fcheck u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_crc32(cfg_crc32), .cfg_fwd_crc(cfg_fwd_crc), .cfg_no_check(cfg_no_check),
      .cfg_len_en(cfg_len_en), .cfg_len_blocks(cfg_len_blocks),
      .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
      .in_eof(in_eof), .in_abort(in_abort),
      .out_valid(out_valid), .out_is_status(out_is_status),
      .out_data(out_data), .msg_end_irq(msg_end_irq)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) got_q.push_back({out_is_status, out_data});
         if (msg_end_irq) irq_n++;
         if (msg_end_irq != (out_valid && out_is_status)) irq_skew++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input int n, input bit w32);
      logic [31:0] c;
      c = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      for (int i = 0; i < n; i++) begin
         for (int b = 0; b < 8; b++) begin
            if (c[0] ^ fr[i][b]) c = (c >> 1) ^ (w32 ? 32'hEDB8_8320 : 32'h0000_8408);
            else                 c = c >> 1;
         end
      end
      return c;
   endfunction

   task automatic build(input int nd, input int seed, input bit corrupt);
      logic [31:0] c;
      for (int i = 0; i < nd; i++) fr[i] = 8'((seed * 37 + i * 13 + 5) & 255);
      fr_n = nd;
      if (!cfg_no_check) begin
         c = ~ref_crc(nd, cfg_crc32);
         for (int k = 0; k < (cfg_crc32 ? 4 : 2); k++) begin
            fr[fr_n] = c[8*k +: 8];
            fr_n++;
         end
      end
      if (corrupt) fr[0] = fr[0] ^ 8'h01;
   endtask

   // endk: 0 closing strobe, 1 abort strobe
   task automatic send(input int endk);
      for (int i = 0; i < fr_n; i++) begin
         @(negedge clk);
         in_valid = 1; in_sof = (i == 0); in_data = fr[i];
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0;
      if (endk == 0) in_eof = 1; else in_abort = 1;
      @(negedge clk);
      in_eof = 0; in_abort = 0;
   endtask

   task automatic model(input int endk);
      int d, lim, k;
      logic [31:0] res;
      bit vld, cok;
      d   = (cfg_no_check || cfg_fwd_crc) ? 0 : (cfg_crc32 ? 4 : 2);
      lim = (int'(cfg_len_blocks) + 1) * 32;
      if (cfg_len_en && fr_n > lim) begin
         k = lim - d;
         for (int i = 0; i < k; i++) exp_q.push_back({1'b0, fr[i]});
         exp_q.push_back(9'h110);
      end else begin
         k = fr_n - d;
         for (int i = 0; i < k; i++) exp_q.push_back({1'b0, fr[i]});
         if (endk == 1) exp_q.push_back(9'h110);
         else begin
            res = ref_crc(fr_n, cfg_crc32);
            cok = !cfg_no_check && (cfg_crc32 ? (res == 32'hDEBB_20E3) : (res[15:0] == 16'hF0B8));
            vld = fr_n >= (cfg_no_check ? 1 : (cfg_crc32 ? 5 : 3));
            exp_q.push_back({1'b1, vld, 1'b0, cok, 5'b0});
         end
      end
   endtask

   task automatic compare(input string req);
      int ns;
      repeat (4) @(negedge clk);
      check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
      ns = 0;
      foreach (exp_q[i]) if (exp_q[i][8]) ns++;
      check(irq_n == ns && irq_skew == 0, {req, " R11"}, irq_n, ns);
      got_q.delete(); exp_q.delete(); irq_n = 0; irq_skew = 0;
   endtask

   task automatic frame(input int nd, input int seed, input bit corrupt, input int endk, input string req);
      build(nd, seed, corrupt);
      model(endk);
      send(endk);
      compare(req);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(out_valid == 0 && msg_end_irq == 0, "R12 reset", out_valid, 0);

      // sweep: CRC width x handling mode x payload length x corruption
      for (int m = 0; m < 6; m++) begin
         cfg_crc32    = m[0];
         cfg_fwd_crc  = (m / 2 == 1);
         cfg_no_check = (m / 2 == 2);
         for (int nd = 0; nd < 7; nd++) begin
            for (int c = 0; c < 2; c++) begin
               if (!(cfg_no_check && nd == 0)) begin
                  if (cfg_no_check)     frame(nd, nd + m, c[0], 0, "R5 R6 R7");
                  else if (cfg_fwd_crc) frame(nd, nd + m, c[0], 0, cfg_crc32 ? "R2 R4 R6" : "R1 R4 R6");
                  else                  frame(nd, nd + m, c[0], 0, cfg_crc32 ? "R2 R3 R6" : "R1 R3 R6");
               end
            end
         end
      end

      // abort inside a frame
      cfg_crc32 = 0; cfg_fwd_crc = 0; cfg_no_check = 0;
      frame(5, 3, 0, 1, "R8 plain");
      cfg_crc32 = 1; cfg_fwd_crc = 1;
      frame(2, 4, 0, 1, "R8 fwd");
      cfg_fwd_crc = 0;
      frame(1, 5, 0, 1, "R8 short");

      // length ceiling
      cfg_len_en = 1; cfg_len_blocks = 11'd0; cfg_crc32 = 0;
      frame(30, 7, 0, 0, "R9 at limit");
      frame(31, 8, 0, 0, "R9 over by one");
      frame(100, 9, 0, 0, "R9 far over");
      cfg_len_blocks = 11'd1; cfg_crc32 = 1;
      frame(60, 10, 0, 0, "R9 at limit 64");
      frame(61, 11, 0, 0, "R9 over 64");
      cfg_fwd_crc = 1;
      frame(70, 12, 0, 1, "R9 over then abort");
      cfg_fwd_crc = 0;
      cfg_len_en = 0; cfg_len_blocks = 11'd0;
      frame(100, 13, 0, 0, "R10 disabled");

      // stray inputs outside any frame
      @(negedge clk); in_valid = 1; in_sof = 0; in_data = 8'h5A;
      @(negedge clk); in_valid = 0; in_eof = 1;
      @(negedge clk); in_eof = 0; in_abort = 1;
      @(negedge clk); in_abort = 0;
      compare("R12 stray");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule